// File: doc/BRIEF.md
# Bit Test and Modify Unit

This unit takes one destination word, a bit position and an operation code, and does two things at once. It reports the chosen bit's value as it was before any change, on a carry output. It also returns the word with that single bit left alone, inverted, forced low or forced high. Execution logic uses it for the four bit-probe operations: probe only, probe-then-set, probe-then-clear and probe-then-flip.

Each request is qualified by a valid strobe. All results are registered, so a result leaves the unit exactly one clock after its request. The write-enable output tells the register file whether the returned word must be stored. The position input may be wider than needed. Only its value modulo the word width is used, which is the same as its low bits because the width is a power of two.

Top module: `bit_probe_unit`

## Requirements
- R1: `out_valid` is high in the cycle after an accepted request (`in_valid` high at a rising edge) and low in the cycle after a cycle with `in_valid` low.
- R2: The selected bit index is `in_pos` modulo WORD_W (32 by default), so only `in_pos[4:0]` matters; for example, positions 37 and 5 select the same bit.
- R3: `out_carry` equals the selected bit of `in_word` as it was before modification, for every operation.
- R4: Operation code 2'b00 (probe only) returns `out_word` equal to `in_word` with `out_wen` low.
- R5: Operation code 2'b11 (flip) returns `in_word` with the selected bit inverted.
- R6: Operation code 2'b10 (clear) returns `in_word` with the selected bit forced to 0.
- R7: Operation code 2'b01 (set) returns `in_word` with the selected bit forced to 1.
- R8: For codes 2'b01, 2'b10 and 2'b11, `out_wen` is high, and `out_word` never differs from `in_word` in more than the selected bit.
- R9: When `in_valid` is low at an edge, `out_word`, `out_carry` and `out_wen` keep their previous values.
- R10: While `rst` is high, all outputs are cleared to 0 at each rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_op | input | 2 | Operation: 00 probe, 01 set, 10 clear, 11 flip |
| in_word | input | WORD_W | Destination word |
| in_pos | input | POS_W | Bit position, reduced modulo WORD_W |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_word | output | WORD_W | Word after modification |
| out_carry | output | 1 | Selected bit before modification |
| out_wen | output | 1 | Write-back required |

## Verification
The hardest cases to reach are those where the operation does not change the word: setting a bit that is already 1, or clearing one that is already 0. In these cases the returned word equals the input, yet the write-enable must still be high and the carry must still report the old bit. Another hard case is a position whose upper bits are non-zero, which must alias to a low index. The stimulus builds words around the chosen bit so that each operation meets both bit polarities, at the edge positions 0 and 31, at aliased positions such as 37 and 255, and with idle gaps between requests. A long stretch of mixed random requests follows, compared cycle by cycle against a behavioural model.

// File: rtl/bit_probe_pkg.sv
package bit_probe_pkg;

    localparam int unsigned DEF_WORD_W = 32;
    localparam int unsigned DEF_POS_W  = 8;

    typedef enum logic [1:0] {
        BP_PROBE = 2'b00,
        BP_SET   = 2'b01,
        BP_CLEAR = 2'b10,
        BP_FLIP  = 2'b11
    } bp_op_e;

    // Write-back is needed for every operation except a pure probe.
    function automatic logic bp_writes(input bp_op_e op);
        return op != BP_PROBE;
    endfunction

    // Single-bit update rule shared by all bit slices.
    function automatic logic bp_bit_next(input bp_op_e op, input logic cur, input logic hit);
        logic nxt;
        nxt = cur;
        if (hit) begin
            unique case (op)
                BP_SET:   nxt = 1'b1;
                BP_CLEAR: nxt = 1'b0;
                BP_FLIP:  nxt = ~cur;
                default:  nxt = cur;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/bit_probe_decode.sv
module bit_probe_decode #(
    parameter int unsigned WORD_W = bit_probe_pkg::DEF_WORD_W,
    parameter int unsigned POS_W  = bit_probe_pkg::DEF_POS_W
) (
    input  logic [POS_W-1:0]  pos,
    output logic [WORD_W-1:0] mask
);
    localparam int unsigned IDX_W = $clog2(WORD_W);

    logic [IDX_W-1:0] idx;

    // WORD_W is a power of two, so the modulo reduction is the low bits.
    assign idx = pos[IDX_W-1:0];

    for (genvar g = 0; g < WORD_W; g++) begin : g_hit
        assign mask[g] = (idx == IDX_W'(g));
    end
endmodule

// File: rtl/bit_probe_modify.sv
module bit_probe_modify #(
    parameter int unsigned WORD_W = bit_probe_pkg::DEF_WORD_W
) (
    input  bit_probe_pkg::bp_op_e op,
    input  logic [WORD_W-1:0]     word,
    input  logic [WORD_W-1:0]     mask,
    output logic [WORD_W-1:0]     word_next,
    output logic                  old_bit,
    output logic                  wen
);
    import bit_probe_pkg::*;

    for (genvar g = 0; g < WORD_W; g++) begin : g_slice
        assign word_next[g] = bp_bit_next(op, word[g], mask[g]);
    end

    assign old_bit = |(word & mask);
    assign wen     = bp_writes(op);
endmodule

// File: rtl/bit_probe_unit.sv
module bit_probe_unit #(
    parameter int unsigned WORD_W = bit_probe_pkg::DEF_WORD_W,
    parameter int unsigned POS_W  = bit_probe_pkg::DEF_POS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        in_op,
    input  logic [WORD_W-1:0] in_word,
    input  logic [POS_W-1:0]  in_pos,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic              out_carry,
    output logic              out_wen
);
    import bit_probe_pkg::*;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              carry;
        logic              wen;
    } bp_result_t;

    logic [WORD_W-1:0] sel_mask;
    bp_result_t        res_d;
    bp_result_t        res_q;
    bp_op_e            op_e;

    assign op_e = bp_op_e'(in_op);

    bit_probe_decode #(.WORD_W(WORD_W), .POS_W(POS_W)) u_decode (
        .pos  (in_pos),
        .mask (sel_mask)
    );

    bit_probe_modify #(.WORD_W(WORD_W)) u_modify (
        .op        (op_e),
        .word      (in_word),
        .mask      (sel_mask),
        .word_next (res_d.word),
        .old_bit   (res_d.carry),
        .wen       (res_d.wen)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_q <= res_d;
            end
        end
    end

    assign out_word  = res_q.word;
    assign out_carry = res_q.carry;
    assign out_wen   = res_q.wen;
endmodule

// File: rtl/bit_probe_unit_chk.sv
module bit_probe_unit_chk #(
    parameter int unsigned WORD_W = bit_probe_pkg::DEF_WORD_W,
    parameter int unsigned POS_W  = bit_probe_pkg::DEF_POS_W
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [1:0]        in_op,
    input logic [WORD_W-1:0] in_word,
    input logic [POS_W-1:0]  in_pos,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_word,
    input logic              out_carry,
    input logic              out_wen
);
    localparam int unsigned IDX_W = $clog2(WORD_W);

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R1
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R1
    AST_CARRY_OLD:  assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_carry == $past(in_word[in_pos[IDX_W-1:0]])); // R3
    AST_PROBE_KEEP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'b00) |=> (!out_wen && out_word == $past(in_word))); // R4
    AST_SET_HIGH:   assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'b01) |=> out_word[$past(in_pos[IDX_W-1:0])]); // R7
    AST_CLEAR_LOW:  assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'b10) |=> !out_word[$past(in_pos[IDX_W-1:0])]); // R6
    AST_FLIP_ONE:   assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'b11) |=> $countones(out_word ^ $past(in_word)) == 1); // R5
    AST_WEN_MOD:    assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op != 2'b00) |=> out_wen); // R8
    AST_ONE_BIT:    assert property (@(posedge clk) disable iff (rst)
        in_valid |=> $countones(out_word ^ $past(in_word)) <= 1); // R8
    AST_IDLE_HOLD:  assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_word) && $stable(out_carry) && $stable(out_wen))); // R9
endmodule

bind bit_probe_unit bit_probe_unit_chk #(.WORD_W(WORD_W), .POS_W(POS_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_word   (in_word),
    .in_pos    (in_pos),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_carry (out_carry),
    .out_wen   (out_wen)
);

// File: tb/bit_probe_unit_tb_top.sv
module bit_probe_unit_tb_top;
    localparam int WORD_W = 32;
    localparam int POS_W  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [1:0]        in_op = 2'b00;
    logic [WORD_W-1:0] in_word = '0;
    logic [POS_W-1:0]  in_pos = '0;
    logic              out_valid;
    logic [WORD_W-1:0] out_word;
    logic              out_carry;
    logic              out_wen;

    int n_cmp  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    bit_probe_unit #(.WORD_W(WORD_W), .POS_W(POS_W)) dut_i (.*);

    // Behavioural reference, updated at each rising edge.
    logic              m_valid = 1'b0;
    logic [WORD_W-1:0] m_word  = '0;
    logic              m_carry = 1'b0;
    logic              m_wen   = 1'b0;
    logic [1:0]        m_op    = 2'b00;
    logic              m_idle  = 1'b0;
    logic              m_alias = 1'b0;

    always @(posedge clk) begin
        int k;
        logic [WORD_W-1:0] w;
        if (rst) begin
            m_valid <= 1'b0; m_word <= '0; m_carry <= 1'b0; m_wen <= 1'b0;
        end else begin
            m_valid <= in_valid;
            m_idle  <= !in_valid;
            if (in_valid) begin
                k = int'(in_pos) % WORD_W;
                w = in_word;
                m_carry <= in_word[k];
                case (in_op)
                    2'b00: begin m_wen <= 1'b0; end
                    2'b01: begin w[k] = 1'b1; m_wen <= 1'b1; end
                    2'b10: begin w[k] = 1'b0; m_wen <= 1'b1; end
                    default: begin w[k] = !w[k]; m_wen <= 1'b1; end
                endcase
                m_word  <= w;
                m_op    <= in_op;
                m_alias <= (int'(in_pos) >= WORD_W);
            end
        end
    end

    function automatic string word_tag(input logic [1:0] op);
        case (op)
            2'b00: return "R4";
            2'b01: return "R7";
            2'b10: return "R6";
            default: return "R5";
        endcase
    endfunction

    task automatic cmp(input string tag, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            if (rst) begin
                cmp("R10 valid", WORD_W'(out_valid), '0);
                cmp("R10 word",  out_word, '0);
                cmp("R10 carry/wen", WORD_W'({out_carry, out_wen}), '0);
            end else begin
                cmp("R1 valid", WORD_W'(out_valid), WORD_W'(m_valid));
                cmp(m_idle ? "R9 hold word" : (m_alias ? "R2 word" : word_tag(m_op)), out_word, m_word);
                cmp(m_idle ? "R9 hold carry" : (m_alias ? "R2 carry" : "R3 carry"),
                    WORD_W'(out_carry), WORD_W'(m_carry));
                cmp(m_idle ? "R9 hold wen" : "R8 wen", WORD_W'(out_wen), WORD_W'(m_wen));
            end
        end
    end

    task automatic send(input logic [1:0] op, input logic [WORD_W-1:0] w, input logic [POS_W-1:0] p);
        @(negedge clk); #1;
        in_valid = 1'b1; in_op = op; in_word = w; in_pos = p;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            in_valid = 1'b0;
            in_op = 2'($urandom); in_word = $urandom; in_pos = 8'($urandom);
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); #1; rst = 1'b0;
        // R4..R7 with both polarities of the chosen bit at edges and aliases (R2)
        for (int op = 0; op < 4; op++) begin
            send(2'(op), 32'h0000_0000, 8'd0);
            send(2'(op), 32'hFFFF_FFFF, 8'd31);
            send(2'(op), 32'h0000_0020, 8'd37);
            send(2'(op), 32'hFFFF_FFDF, 8'd37);
            send(2'(op), 32'h8000_0000, 8'd255);
            idle(2);
            send(2'(op), 32'hA5A5_5A5A, 8'd224);
        end
        idle(3);
        // R9: hold across gaps, R1 strobe pattern
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(3) == 0) idle(1);
            else send(2'($urandom), $urandom, 8'($urandom));
        end
        idle(2);
        // R10: reset in the middle of traffic
        send(2'b11, 32'hFFFF_0000, 8'd3);
        @(negedge clk); #1; rst = 1'b1; in_valid = 1'b1;
        repeat (2) @(negedge clk);
        #1; rst = 1'b0; in_valid = 1'b0;
        idle(2);
        send(2'b01, 32'h0, 8'd17);
        idle(2);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end
endmodule